// File: doc/BRIEF.md
# Serial Link Channel Status Monitor

This block watches a single logical channel of a shared serial media link. It keeps three sticky status flags: protocol error, break and service request. A separate decoder upstream has already validated the byte stream, and this block receives each command or status byte from it with a strobe. The meaning of a byte depends on the channel's direction. A transmit channel receives status bytes back from the far receiver. A receive channel receives command bytes from the far transmitter.

For receive channels the block tracks whether a packet is in progress, so that a start command that arrives inside a packet can be reported. It also compares the local buffer level against a 10-bit threshold to raise a service request. For a receive channel that level is the number of free quadlets. For a transmit channel it is the number of valid quadlets.

Each flag stays set until software pulses that flag's own clear strobe. A registered, maskable interrupt combines the three flags into one request.

Top module: `chan_status_mon`

## Requirements
- R1: On a transmit channel (`dir_tx`=1) whose type is asynchronous (`ch_type`=2) or control (`ch_type`=3), a strobed byte 0x72 sets `status[0]` (protocol error) at the clock edge that samples it. On synchronous (0) or isochronous (1) transmit channels, and for any other transmit byte, `status[0]` is not set.
- R2: On a receive channel, a strobed command that is not valid for the channel type sets `status[0]`. The valid commands are as follows. 0x00 is valid for every type. 0x10 is valid for synchronous channels only. 0x18 is valid for isochronous channels only. 0x20 and 0x26 are valid for asynchronous channels only. 0x30 and 0x36 are valid for control channels only.
- R3: On a receive channel, the start command of the channel's own type (0x20 for asynchronous, 0x30 for control) opens a packet. If that start command arrives while a packet is already open, it sets `status[0]`. A packet is closed by `pkt_end` or by a valid break command.
- R4: `status[1]` (break) is set in three cases: a transmit asynchronous or control channel receives byte 0x70; a receive asynchronous channel receives 0x26; a receive control channel receives 0x36. This applies whether or not a packet is open. Synchronous and isochronous channels never set it.
- R5: On a receive channel, `status[2]` (service request) is set at every edge where `level` (free quadlets) is less than or equal to `threshold`.
- R6: On a transmit channel, `status[2]` is set at every edge where `level` (valid quadlets) is less than or equal to `threshold`.
- R7: Every status bit stays set until its own `clr` bit is high at an edge. If a set event for a bit occurs at the same edge as its clear, the bit is set.
- R8: `irq` is registered. At each edge it takes the OR of `status & irq_mask` as sampled at that edge, so it follows a flag change one cycle later. A mask bit of 1 enables the corresponding status bit.
- R9: While `rst_n` is low, `status`, `irq` and the packet state are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| code_vld | input | 1 | Strobe for `code_in` |
| code_in | input | 8 | Command byte (receive) or status byte (transmit) |
| pkt_end | input | 1 | End-of-packet strobe for a receive channel |
| ch_type | input | 2 | 0 synchronous, 1 isochronous, 2 asynchronous, 3 control |
| dir_tx | input | 1 | 1 transmit, 0 receive |
| level | input | LVL_W | Free (receive) or valid (transmit) quadlets in the local buffer |
| threshold | input | TH_W | Service-request threshold |
| irq_mask | input | 3 | Per-flag interrupt enable |
| clr | input | 3 | Per-flag clear strobe |
| status | output | 3 | [0] protocol error, [1] break, [2] service request |
| irq | output | 1 | Combined channel interrupt |

## Verification
The assertions check on every cycle the properties that hold edge by edge:
- flags stay set when they are not cleared;
- the interrupt follows the masked flags one cycle later;
- the service request rises whenever the level is at or below the threshold;
- a transmit 0x72 on an asynchronous or control channel gives an error;
- the two break commands are honoured on a receive channel;
- synchronous and isochronous channels never raise break.

Only the bench scenarios can show the rest. Those are the full decode of all 256 byte values, for every type and direction, with a packet both open and closed. They also cover the packet-state history: a start after `pkt_end`, a start after a break, and a repeated start. Finally they cover clear-versus-event priority and every combination of flag pattern and mask.

// File: rtl/chan_status_mon.sv
module chan_status_mon #(
  parameter int LVL_W = 11,
  parameter int TH_W  = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             code_vld,
  input  logic [7:0]       code_in,
  input  logic             pkt_end,
  input  logic [1:0]       ch_type,
  input  logic             dir_tx,
  input  logic [LVL_W-1:0] level,
  input  logic [TH_W-1:0]  threshold,
  input  logic [2:0]       irq_mask,
  input  logic [2:0]       clr,
  output logic [2:0]       status,
  output logic             irq
);
  localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;

  localparam logic [7:0] C_NOP        = 8'h00;
  localparam logic [7:0] C_SYNC       = 8'h10;
  localparam logic [7:0] C_ISO        = 8'h18;
  localparam logic [7:0] C_ASY_START  = 8'h20;
  localparam logic [7:0] C_ASY_BREAK  = 8'h26;
  localparam logic [7:0] C_CTL_START  = 8'h30;
  localparam logic [7:0] C_CTL_BREAK  = 8'h36;
  localparam logic [7:0] S_RX_BREAK   = 8'h70;
  localparam logic [7:0] S_RX_PROTERR = 8'h72;

  logic is_sync, is_iso, is_asy, is_ctl, pkt_q, irq_q;
  logic [2:0] flags_q, set_vec;

  assign is_sync = (ch_type == 2'd0);
  assign is_iso  = (ch_type == 2'd1);
  assign is_asy  = (ch_type == 2'd2);
  assign is_ctl  = (ch_type == 2'd3);

  wire rx_ev = code_vld & ~dir_tx;
  wire tx_ev = code_vld &  dir_tx;

  wire is_start = (is_asy & (code_in == C_ASY_START)) | (is_ctl & (code_in == C_CTL_START));
  wire is_break = (is_asy & (code_in == C_ASY_BREAK)) | (is_ctl & (code_in == C_CTL_BREAK));
  wire cmd_ok   = (code_in == C_NOP) | (is_sync & (code_in == C_SYNC)) |
                  (is_iso & (code_in == C_ISO)) | is_start | is_break;

  wire [CMP_W-1:0] lvl_x = CMP_W'(level);
  wire [CMP_W-1:0] th_x  = CMP_W'(threshold);

  assign set_vec[0] = (tx_ev & ch_type[1] & (code_in == S_RX_PROTERR)) |
                      (rx_ev & (~cmd_ok | (is_start & pkt_q)));
  assign set_vec[1] = (tx_ev & ch_type[1] & (code_in == S_RX_BREAK)) | (rx_ev & is_break);
  assign set_vec[2] = (lvl_x <= th_x);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
      pkt_q   <= 1'b0;
    end else begin
      flags_q <= set_vec | (flags_q & ~clr);
      irq_q   <= |(flags_q & irq_mask);
      if (rx_ev & is_start & ~pkt_q)
        pkt_q <= 1'b1;
      else if ((rx_ev & is_break) | pkt_end)
        pkt_q <= 1'b0;
    end
  end

  assign status = flags_q;
  assign irq    = irq_q;
endmodule

// File: rtl/chan_status_mon_chk.sv
module chan_status_mon_chk #(
  parameter int LVL_W = 11,
  parameter int TH_W  = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic             code_vld,
  input logic [7:0]       code_in,
  input logic [1:0]       ch_type,
  input logic             dir_tx,
  input logic [LVL_W-1:0] level,
  input logic [TH_W-1:0]  threshold,
  input logic [2:0]       irq_mask,
  input logic [2:0]       clr,
  input logic [2:0]       status,
  input logic             irq
);
  localparam int CMP_W = (LVL_W > TH_W) ? LVL_W : TH_W;

  AST_TX_PROTERR: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && dir_tx && ch_type[1] && code_in == 8'h72) |=> status[0]); // R1
  AST_RX_BREAK: assert property (@(posedge clk) disable iff (!rst_n)
    (code_vld && !dir_tx && ((ch_type == 2'd2 && code_in == 8'h26) ||
     (ch_type == 2'd3 && code_in == 8'h36))) |=> status[1]); // R4
  AST_NO_BREAK_STREAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!ch_type[1] && !status[1]) |=> !status[1]); // R4
  AST_SRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (CMP_W'(level) <= CMP_W'(threshold)) |=> status[2]); // R5 R6
  AST_STICKY_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (status[0] && !clr[0]) |=> status[0]); // R7
  AST_STICKY_BRK: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && !clr[1]) |=> status[1]); // R7
  AST_STICKY_SRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2] && !clr[2]) |=> status[2]); // R7
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq == $past(|(status & irq_mask)))); // R8

  always_comb begin
    if (!rst_n) begin
      AST_RESET_QUIET: assert (status == 3'b000 && irq == 1'b0); // R9
    end
  end
endmodule

bind chan_status_mon chan_status_mon_chk #(.LVL_W(LVL_W), .TH_W(TH_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code_in(code_in),
  .ch_type(ch_type), .dir_tx(dir_tx), .level(level), .threshold(threshold),
  .irq_mask(irq_mask), .clr(clr), .status(status), .irq(irq)
);

// File: tb/chan_status_mon_bench.sv
module chan_status_mon_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic code_vld = 1'b0;
  logic [7:0] code_in = 8'h00;
  logic pkt_end = 1'b0;
  logic [1:0] ch_type = 2'd0;
  logic dir_tx = 1'b0;
  logic [10:0] level = 11'd2047;
  logic [9:0] threshold = 10'd5;
  logic [2:0] irq_mask = 3'b000;
  logic [2:0] clr = 3'b000;
  logic [2:0] status;
  logic irq;
  int vectors = 0;
  int errs = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  chan_status_mon u_chan_status_mon (
    .clk(clk), .rst_n(rst_n), .code_vld(code_vld), .code_in(code_in),
    .pkt_end(pkt_end), .ch_type(ch_type), .dir_tx(dir_tx), .level(level),
    .threshold(threshold), .irq_mask(irq_mask), .clr(clr),
    .status(status), .irq(irq)
  );

  task automatic vec(input logic v, input logic [7:0] c, input logic pe, input logic [2:0] cl);
    code_vld = v; code_in = c; pkt_end = pe; clr = cl;
    @(posedge clk); #1;
    code_vld = 1'b0; pkt_end = 1'b0; clr = 3'b000;
  endtask

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    vectors++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h (type %0d tx %0d code %h)", req, got, exp, ch_type, dir_tx, code_in);
    end
  endtask

  function automatic logic [7:0] start_of(input int t);
    return (t == 2) ? 8'h20 : 8'h30;
  endfunction

  // expected {brk, err} for one strobed byte, per R1-R4
  function automatic logic [1:0] expect_ev(input int t, input int tx, input logic [7:0] b, input int act);
    logic ok, st, bk;
    if (tx != 0) begin
      if (t >= 2) return {b == 8'h70, b == 8'h72};
      return 2'b00;
    end
    st = (t == 2 && b == 8'h20) || (t == 3 && b == 8'h30);
    bk = (t == 2 && b == 8'h26) || (t == 3 && b == 8'h36);
    ok = (b == 8'h00) || (t == 0 && b == 8'h10) || (t == 1 && b == 8'h18) || st || bk;
    return {bk, !ok || (st && act != 0)};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    chk("R9 status in reset", {5'd0, status}, 8'h00);
    chk("R9 irq in reset", {7'd0, irq}, 8'h00);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // full decode sweep: R1 R2 R3 R4
    for (int t = 0; t < 4; t++)
      for (int d = 0; d < 2; d++)
        for (int b = 0; b < 256; b++)
          for (int a = 0; a < 2; a++) begin
            if (a == 1 && !(d == 0 && t >= 2)) continue;
            ch_type = 2'(t); dir_tx = d[0];
            if (a == 1) vec(1'b1, start_of(t), 1'b0, 3'b111);
            vec(1'b1, 8'(b), 1'b0, 3'b000);
            chk(d ? "R1/R4 tx decode" : "R2/R3/R4 rx decode", {5'd0, status},
                {6'd0, expect_ev(t, d, 8'(b), a)});
            vec(1'b0, 8'h00, 1'b1, 3'b111);
            chk("R7 clear all", {5'd0, status}, 8'h00);
          end

    // threshold sweep: R5 (rx) R6 (tx)
    for (int d = 0; d < 2; d++)
      for (int k = 0; k < 3; k++)
        for (int off = -2; off <= 2; off++) begin
          int th, lv;
          th = (k == 0) ? 0 : (k == 1) ? 7 : 1023;
          lv = th + off;
          if (lv < 0) continue;
          dir_tx = d[0]; ch_type = 2'd1; threshold = 10'(th); level = 11'd2047;
          vec(1'b0, 8'h00, 1'b0, 3'b111);
          level = 11'(lv);
          vec(1'b0, 8'h00, 1'b0, 3'b000);
          chk(d ? "R6 tx service level" : "R5 rx service level", {7'd0, status[2]}, {7'd0, 1'(lv <= th)});
          level = 11'd2047;
        end
    threshold = 10'd5;

    // sticky and clear priority: R7
    ch_type = 2'd3; dir_tx = 1'b1;
    vec(1'b0, 8'h00, 1'b0, 3'b111);
    vec(1'b1, 8'h72, 1'b0, 3'b000);
    for (int i = 0; i < 4; i++) begin
      vec(1'b0, 8'h00, 1'b0, 3'b000);
      chk("R7 error held", {5'd0, status}, 8'h01);
    end
    vec(1'b1, 8'h72, 1'b0, 3'b001);
    chk("R7 event beats clear", {5'd0, status}, 8'h01);
    vec(1'b1, 8'h70, 1'b0, 3'b001);
    chk("R7 clear err keeps new brk", {5'd0, status}, 8'h02);
    vec(1'b0, 8'h00, 1'b0, 3'b010);
    chk("R7 clear brk", {5'd0, status}, 8'h00);

    // packet history: R3 R4
    ch_type = 2'd3; dir_tx = 1'b0;
    vec(1'b1, 8'h30, 1'b0, 3'b111);
    chk("R3 first start", {5'd0, status}, 8'h00);
    vec(1'b0, 8'h00, 1'b1, 3'b000);
    vec(1'b1, 8'h30, 1'b0, 3'b000);
    chk("R3 start after end", {5'd0, status}, 8'h00);
    vec(1'b1, 8'h36, 1'b0, 3'b000);
    chk("R4 break in packet", {5'd0, status}, 8'h02);
    vec(1'b1, 8'h30, 1'b0, 3'b000);
    chk("R3 start after break", {5'd0, status}, 8'h02);
    vec(1'b1, 8'h30, 1'b0, 3'b000);
    chk("R3 repeated start", {5'd0, status}, 8'h03);
    vec(1'b1, 8'h36, 1'b0, 3'b111);
    vec(1'b1, 8'h36, 1'b0, 3'b011);
    chk("R4 break while idle", {5'd0, status}, 8'h02);

    // interrupt vs flag pattern and mask: R8
    ch_type = 2'd3; dir_tx = 1'b1;
    for (int p = 0; p < 8; p++)
      for (int m = 0; m < 8; m++) begin
        irq_mask = 3'b000;
        vec(1'b0, 8'h00, 1'b0, 3'b111);
        vec(p[0], 8'h72, 1'b0, 3'b000);
        if (p[2]) level = 11'd0;
        vec(p[1], 8'h70, 1'b0, 3'b000);
        level = 11'd2047;
        chk("R8 pattern built", {5'd0, status}, 8'(p));
        irq_mask = 3'(m);
        vec(1'b0, 8'h00, 1'b0, 3'b000);
        chk("R8 masked irq", {7'd0, irq}, {7'd0, 1'((p & m) != 0)});
      end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule